// File: doc/BRIEF.md
# FIFO Level Threshold Interrupt Unit

This unit sits beside the two FIFOs of an I2C host controller and turns their fill levels into latched interrupt events. The command FIFO is written by software and drained by the bus engine. The receive FIFO is filled by the bus engine and read by software. A small selector code per FIFO picks a threshold from a fixed, non-linear set of levels. When a level crosses its threshold, the matching state bit is set and held until software clears it.

The command event is raised on both directions of crossing. It fires when the level climbs to the threshold and again when it drains below it. The receive event is raised only when the level climbs to the threshold. Receive selector codes above the last defined one turn that event off completely. Each interrupt pin is the state bit gated by its enable. Bit 0 of every two-bit vector belongs to the command FIFO and bit 1 to the receive FIFO.

Top module: `fifo_thr_intr`

## Requirements
- R1: The command selector `fmt_thr_sel_i` (3 bits) maps code 0 to level 1, code 1 to level 4, code 2 to level 8, and codes 3 through 7 to level 16.
- R2: The receive selector `rx_thr_sel_i` (3 bits) maps code 0 to level 1, code 1 to level 4, code 2 to level 8, code 3 to level 16 and code 4 to level 30.
- R3: With a receive selector code of 5, 6 or 7, bit 1 of `intr_state_o` is never set by any level sequence.
- R4: The receive event fires exactly once, on the cycle whose sampled level first satisfies level >= threshold. A jump from threshold-1 straight to threshold+1 also gives one event, and a falling level gives none.
- R5: The command event fires when the level rises to reach the threshold (level >= threshold). It fires again when the level falls below the threshold (level < threshold).
- R6: A level that changes but stays on the same side of its threshold produces no event.
- R7: A state bit, once set, stays set until a one is written to its bit of `intr_clr_i` with no new event in that cycle. It is then clear after the next clock edge.
- R8: Each bit of `intr_o` equals the same bit of `intr_state_o` ANDed with `intr_en_i`. The enable never changes the state bit.
- R9: If an event and a clear for the same bit fall in the same cycle, the state bit is set after that edge.
- R10: Reset clears both state bits and the crossing history. No event is taken at the first clock edge after reset is released, even if a level already sits at or above its threshold.
- R11: An event is visible on `intr_state_o` after the first rising clock edge that samples the crossing level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_lvl_i | input | 6 | Command FIFO fill level, 0 to 32 |
| rx_lvl_i | input | 6 | Receive FIFO fill level, 0 to 32 |
| fmt_thr_sel_i | input | 3 | Command threshold selector code |
| rx_thr_sel_i | input | 3 | Receive threshold selector code |
| intr_en_i | input | 2 | Interrupt enables, bit 0 command, bit 1 receive |
| intr_clr_i | input | 2 | Write-one-to-clear strobes for the state bits |
| intr_state_o | output | 2 | Latched interrupt state bits |
| intr_o | output | 2 | Enable-gated interrupt pins |

## Verification
Every result is due one clock edge after its stimulus. The stimulus is a level, a clear strobe, or the reset release. Inputs change on the falling edge, so the state bits are read on the following falling edge, after exactly one rising edge. Most sweeps hold the clear strobes high. Because a new event wins over a clear, each state bit then reads as the per-cycle event, which lets every step of a ramp be compared with the expected crossing on its own. The enable gating is combinational on the state. It is therefore checked on the same falling edge, with no extra cycle.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;
  parameter int unsigned LVL_W    = 6;
  parameter int unsigned SEL_W    = 3;
  parameter int unsigned NUM_INTR = 2;
  localparam int unsigned FMT_IDX = 0;
  localparam int unsigned RX_IDX  = 1;

  typedef struct packed {
    logic             valid;
    logic [LVL_W-1:0] level;
  } thr_cfg_t;

  // R1
  function automatic thr_cfg_t fmt_thr_map(logic [SEL_W-1:0] sel);
    thr_cfg_t c;
    c.valid = 1'b1;
    case (sel)
      SEL_W'(0): c.level = LVL_W'(1);
      SEL_W'(1): c.level = LVL_W'(4);
      SEL_W'(2): c.level = LVL_W'(8);
      default:   c.level = LVL_W'(16);
    endcase
    return c;
  endfunction

  // R2, R3
  function automatic thr_cfg_t rx_thr_map(logic [SEL_W-1:0] sel);
    thr_cfg_t c;
    c.valid = 1'b1;
    case (sel)
      SEL_W'(0): c.level = LVL_W'(1);
      SEL_W'(1): c.level = LVL_W'(4);
      SEL_W'(2): c.level = LVL_W'(8);
      SEL_W'(3): c.level = LVL_W'(16);
      SEL_W'(4): c.level = LVL_W'(30);
      default: begin
        c.valid = 1'b0;
        c.level = '0;
      end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/thr_crossing.sv
module thr_crossing #(
  parameter int unsigned LVL_W      = 6,
  parameter bit          BOTH_EDGES = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] thr_i,
  input  logic             thr_valid_i,
  output logic             evt_o
);
  logic cmp, prev_q, primed_q, rise, fall, raw_evt;

  assign cmp  = thr_valid_i && (lvl_i >= thr_i);
  assign rise = cmp & ~prev_q;
  assign fall = ~cmp & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cmp;
      primed_q <= 1'b1;
    end
  end

  generate
    if (BOTH_EDGES) begin : g_both
      assign raw_evt = rise | fall;
    end else begin : g_rise
      assign raw_evt = rise;

      // R4
      rise_at_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |-> (thr_valid_i && lvl_i >= thr_i));
      // R4
      no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |=> !evt_o);
    end
  endgenerate

  // first edge after reset only loads history
  assign evt_o = raw_evt & primed_q;

  // R10
  no_evt_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> !evt_o);
endmodule

// File: rtl/intr_state_bit.sv
module intr_state_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic state_o,
  output logic intr_o
);
  logic state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= 1'b0;
    else if (set_i) state_q <= 1'b1;
    else if (clr_i) state_q <= 1'b0;
  end

  assign state_o = state_q;
  assign intr_o  = state_q & en_i;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> state_o);
  // R7
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !state_o);
  // R7
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(state_o));
endmodule

// File: rtl/fifo_thr_intr.sv
module fifo_thr_intr
  import fifo_thr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LVL_W-1:0]    fmt_lvl_i,
  input  logic [LVL_W-1:0]    rx_lvl_i,
  input  logic [SEL_W-1:0]    fmt_thr_sel_i,
  input  logic [SEL_W-1:0]    rx_thr_sel_i,
  input  logic [NUM_INTR-1:0] intr_en_i,
  input  logic [NUM_INTR-1:0] intr_clr_i,
  output logic [NUM_INTR-1:0] intr_state_o,
  output logic [NUM_INTR-1:0] intr_o
);
  thr_cfg_t            fmt_cfg, rx_cfg;
  logic [NUM_INTR-1:0] evt;

  assign fmt_cfg = fmt_thr_map(fmt_thr_sel_i);
  assign rx_cfg  = rx_thr_map(rx_thr_sel_i);

  thr_crossing #(.LVL_W(LVL_W), .BOTH_EDGES(1'b1)) u_fmt_cross (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (fmt_lvl_i),
    .thr_i       (fmt_cfg.level),
    .thr_valid_i (fmt_cfg.valid),
    .evt_o       (evt[FMT_IDX])
  );

  thr_crossing #(.LVL_W(LVL_W), .BOTH_EDGES(1'b0)) u_rx_cross (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (rx_lvl_i),
    .thr_i       (rx_cfg.level),
    .thr_valid_i (rx_cfg.valid),
    .evt_o       (evt[RX_IDX])
  );

  for (genvar i = 0; i < NUM_INTR; i++) begin : g_state
    intr_state_bit u_bit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (evt[i]),
      .clr_i   (intr_clr_i[i]),
      .en_i    (intr_en_i[i]),
      .state_o (intr_state_o[i]),
      .intr_o  (intr_o[i])
    );
  end

  // R3
  rx_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_thr_sel_i > SEL_W'(4)) |-> !evt[RX_IDX]);
  // R8
  pin_needs_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_o & ~intr_state_o) == '0);
endmodule

// File: tb/fifo_thr_intr_tb.sv
module fifo_thr_intr_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] fmt_lvl_i = '0, rx_lvl_i = '0;
  logic [2:0] fmt_thr_sel_i = '0, rx_thr_sel_i = '0;
  logic [1:0] intr_en_i = '0, intr_clr_i = '0;
  logic [1:0] intr_state_o, intr_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fifo_thr_intr u_dut (.*);

  function automatic int exp_fmt_thr(int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction
  // 0 means disabled
  function automatic int exp_rx_thr(int c);
    case (c)
      0: return 1;
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 30;
      default: return 0;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b (state,intr)", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R10: reset state and no event on the first edge with levels already high
    fmt_lvl_i = 6'd32; rx_lvl_i = 6'd32; intr_en_i = 2'b11;
    tick();
    chk("R10", {intr_state_o, intr_o}, 4'b0000);
    rst_ni = 1'b1;
    tick();
    chk("R10", {intr_state_o, intr_o}, 4'b0000);
    tick(); tick();
    chk("R10", {intr_state_o, intr_o}, 4'b0000);

    // R1 R2 R3 R4 R5 R6 R9 R11: ramp sweeps with clear held high
    for (int c = 0; c < 8; c++) begin
      int ft, rt;
      ft = exp_fmt_thr(c); rt = exp_rx_thr(c);
      fmt_lvl_i = '0; rx_lvl_i = '0;
      fmt_thr_sel_i = 3'(c); rx_thr_sel_i = 3'(c);
      intr_clr_i = 2'b11; intr_en_i = 2'b11;
      do_reset();
      tick();
      for (int l = 1; l <= 32; l++) begin
        logic [1:0] e;
        fmt_lvl_i = 6'(l); rx_lvl_i = 6'(l);
        tick();
        e = {(rt != 0 && l == rt), (l == ft)};
        chk(c > 4 ? "R3 rise" : "R1 R2 R5 rise", {intr_state_o, intr_o}, {e, e});
      end
      for (int l = 31; l >= 0; l--) begin
        logic [1:0] e;
        fmt_lvl_i = 6'(l); rx_lvl_i = 6'(l);
        tick();
        e = {1'b0, (l == ft - 1)};
        chk("R4 R5 R6 fall", {intr_state_o, intr_o}, {e, e});
      end
    end

    // R4: receive level skips over the threshold by one
    for (int c = 0; c < 5; c++) begin
      int rt;
      rt = exp_rx_thr(c);
      rx_thr_sel_i = 3'(c); rx_lvl_i = 6'(rt - 1); fmt_lvl_i = '0;
      intr_clr_i = 2'b11;
      do_reset();
      tick();
      rx_lvl_i = 6'(rt + 1);
      tick();
      chk("R4 skip", {intr_state_o, intr_o}, 4'b1010);
      rx_lvl_i = 6'(rt + 2);
      tick();
      chk("R4 skip once", {intr_state_o, intr_o}, 4'b0000);
    end

    // R7 R8: latching, enable gating, clear
    fmt_thr_sel_i = 3'd1; rx_thr_sel_i = 3'd1;
    fmt_lvl_i = '0; rx_lvl_i = '0; intr_clr_i = 2'b00; intr_en_i = 2'b00;
    do_reset();
    tick();
    fmt_lvl_i = 6'd4; rx_lvl_i = 6'd5;
    tick();
    chk("R8 masked", {intr_state_o, intr_o}, 4'b1100);
    fmt_lvl_i = 6'd9; rx_lvl_i = 6'd9;
    tick(); tick(); tick();
    chk("R7 hold", {intr_state_o, intr_o}, 4'b1100);
    intr_en_i = 2'b01;
    #1;
    chk("R8 fmt en", {intr_state_o, intr_o}, 4'b1101);
    intr_en_i = 2'b10;
    #1;
    chk("R8 rx en", {intr_state_o, intr_o}, 4'b1110);
    intr_clr_i = 2'b10;
    tick();
    chk("R7 clr rx", {intr_state_o, intr_o}, 4'b0100);
    intr_clr_i = 2'b01; intr_en_i = 2'b11;
    tick();
    chk("R7 clr fmt", {intr_state_o, intr_o}, 4'b0000);
    intr_clr_i = 2'b00;
    fmt_lvl_i = 6'd3;
    tick();
    chk("R5 drain", {intr_state_o, intr_o}, 4'b0101);
    // R9: new event and clear together
    intr_clr_i = 2'b01; fmt_lvl_i = 6'd4;
    tick();
    chk("R9", {intr_state_o, intr_o}, 4'b0101);
    intr_clr_i = 2'b00;
    tick();
    chk("R9 kept", {intr_state_o, intr_o}, 4'b0101);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule